// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor load/store port and a slower memory that moves whole blocks at a time. Every byte address is cut into three fields: the low bits choose a byte inside a block, the middle bits choose one set, and the upper bits form the tag that is kept beside each stored line. All ways of the chosen set are compared in parallel. A valid line whose tag matches is a hit, and a hit finishes in the same cycle that the request is presented.

On a miss the processor is held off. The controller chooses a line to replace. An empty line is always used before an occupied one. When the set is full, the victim is any way except the one used last in that set. A victim that holds modified data is first copied back to memory. The missing block is then fetched into the freed line. The original access is then retried and hits. Stores follow a write-back, write-allocate policy: a store only changes the cached copy and marks it modified, and a store miss first brings the block in and then applies the store.

Top module: `cwb_cache`

## Requirements
- R1: After reset every line is invalid. `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: The set is chosen by address bits [OFF_W +: IDX_W], which are bits [5:4] by default. A block fetch presents the access address with its low OFF_W bits cleared. Accesses to one set never disturb the lines of another set.
- R3: A read that hits raises `cpu_ready` in the cycle it is presented. `cpu_rdata` then carries the 32-bit word selected by address bits [OFF_W-1:2], where word k sits at bits [32k+31:32k] of the block.
- R4: A store that hits changes only the addressed word of the cached line and marks the line modified. It causes no memory request.
- R5: A miss whose victim is valid and modified first issues a block write (`mem_we`=1) of the victim's whole line to the victim's own block address. The block read (`mem_we`=0) for the missing block follows that write.
- R6: A miss whose victim is empty or unmodified issues no block write and goes straight to the block read.
- R7: A store miss fetches the block, then applies the store and marks the line modified. When that line is later evicted, the written-back block contains the stored word merged with the fetched data.
- R8: On a miss, an invalid way of the set is filled before any valid line is evicted.
- R9: When the set is full, the victim is never the way that was most recently hit or filled in that set.
- R10: While a memory request is pending, `cpu_ready` stays low. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes on this cycle's edge |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 for a block write-back, 0 for a block fetch |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | BLOCK_BYTES*8 | Block being written back |
| mem_rdata | input | BLOCK_BYTES*8 | Fetched block, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer done, one-cycle pulse |

## Verification
The assertions assume that the processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` unchanged from the moment it raises a request until the cycle in which `cpu_ready` completes it. They also assume that addresses are word aligned, and that memory raises `mem_ack` only while `mem_req` is high, for a single cycle. The stimulus drives each access one cycle after a clock edge and holds it until it sees `cpu_ready`, then drops it. All addresses it uses are multiples of four. Its memory model waits a few cycles and then pulses the acknowledge once per request. Address sequences are chosen so that sets fill up, empty ways are reused, and modified lines are evicted in a known order.

// File: rtl/cwb_pkg.sv
`timescale 1ns/1ps
package cwb_pkg;

    // Miss-handling sequence of the controller
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cwb_state_e;

    localparam int WORD_BITS  = 32;
    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/cwb_lookup.sv
`timescale 1ns/1ps
module cwb_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 10,
    parameter int WAY_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            way_o
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o = |match;

    // R3: a tag is never held twice in one set, so at most one way matches
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/cwb_victim.sv
`timescale 1ns/1ps
module cwb_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] mru_i,
    output logic [WAY_W-1:0] way_o
);

    logic found;

    // Lowest empty way first; otherwise lowest way that is not the MRU one
    always_comb begin
        way_o = '0;
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_i[w]) begin
                way_o = WAY_W'(w);
                found = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && (WAY_W'(w) != mru_i)) begin
                way_o = WAY_W'(w);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cwb_cache.sv
`timescale 1ns/1ps
module cwb_cache
    import cwb_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BLOCK_BYTES = 16,
    parameter int SETS        = 4,
    parameter int WAYS        = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [31:0]                cpu_wdata,
    output logic                       cpu_ready,
    output logic [31:0]                cpu_rdata,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [BLOCK_BYTES*8-1:0]   mem_wdata,
    input  logic [BLOCK_BYTES*8-1:0]   mem_rdata,
    input  logic                       mem_ack
);

    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_N_W = ADDR_W - OFF_W;
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int BLOCK_W = BLOCK_BYTES * 8;
    localparam int WPB     = BLOCK_BYTES / WORD_BYTES;
    localparam int WSEL_W  = (WPB > 1) ? $clog2(WPB) : 1;

    typedef struct packed {
        cwb_state_e                                fsm;
        logic [WAY_W-1:0]                          vway;
        logic [BLK_N_W-1:0]                        mblk;
        logic [SETS-1:0][WAYS-1:0]                 valid;
        logic [SETS-1:0][WAYS-1:0]                 dirty;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]      tag;
        logic [SETS-1:0][WAYS-1:0][BLOCK_W-1:0]    data;
        logic [SETS-1:0][WAY_W-1:0]                mru;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Address fields of the current request
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_wsel = WSEL_W'(cpu_addr[OFF_W-1:2]);

    // Fields of the block under miss handling
    logic [IDX_W-1:0] m_idx;
    logic [TAG_W-1:0] m_tag;
    assign m_idx = ctl_q.mblk[IDX_W-1:0];
    assign m_tag = ctl_q.mblk[BLK_N_W-1:IDX_W];

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] vic_way;

    cwb_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (ctl_q.valid[a_idx]),
        .tags_i  (ctl_q.tag[a_idx]),
        .tag_i   (a_tag),
        .hit_o   (hit),
        .way_o   (hit_way)
    );

    cwb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_i (ctl_q.valid[a_idx]),
        .mru_i   (ctl_q.mru[a_idx]),
        .way_o   (vic_way)
    );

    logic [BLOCK_W-1:0] hit_line;
    assign hit_line  = ctl_q.data[a_idx][hit_way];
    assign cpu_ready = (ctl_q.fsm == ST_IDLE) && hit;
    assign cpu_rdata = hit_line[a_wsel*WORD_BITS +: WORD_BITS];

    assign mem_req   = (ctl_q.fsm != ST_IDLE);
    assign mem_we    = (ctl_q.fsm == ST_WBACK);
    assign mem_wdata = ctl_q.data[m_idx][ctl_q.vway];
    assign mem_addr  = (ctl_q.fsm == ST_WBACK)
                     ? {ctl_q.tag[m_idx][ctl_q.vway], m_idx, {OFF_W{1'b0}}}
                     : {ctl_q.mblk, {OFF_W{1'b0}}};

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.fsm)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        ctl_d.mru[a_idx] = hit_way;
                        if (cpu_we) begin
                            ctl_d.data[a_idx][hit_way][a_wsel*WORD_BITS +: WORD_BITS] = cpu_wdata;
                            ctl_d.dirty[a_idx][hit_way] = 1'b1;
                        end
                    end else begin
                        ctl_d.vway = vic_way;
                        ctl_d.mblk = cpu_addr[ADDR_W-1:OFF_W];
                        ctl_d.fsm  = (ctl_q.valid[a_idx][vic_way] && ctl_q.dirty[a_idx][vic_way])
                                   ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    ctl_d.dirty[m_idx][ctl_q.vway] = 1'b0;
                    ctl_d.fsm = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    ctl_d.data[m_idx][ctl_q.vway]  = mem_rdata;
                    ctl_d.tag[m_idx][ctl_q.vway]   = m_tag;
                    ctl_d.valid[m_idx][ctl_q.vway] = 1'b1;
                    ctl_d.dirty[m_idx][ctl_q.vway] = 1'b0;
                    ctl_d.mru[m_idx]               = ctl_q.vway;
                    ctl_d.fsm                      = ST_IDLE;
                end
            end
            default: ctl_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Input assumption: word-aligned processor addresses
    a_in_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[1:0] == 2'b00));

    // R10: processor stalled while memory is busy
    a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R10: memory request held steady until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: a finished write-back is followed by a block fetch
    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R8: with an empty way present, the chosen line is empty
    a_r8_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == ST_IDLE && cpu_req && !hit && !(&ctl_q.valid[a_idx]))
        |=> !ctl_q.valid[$past(a_idx)][ctl_q.vway]);

    if (WAYS > 1) begin : g_nmru_chk
        // R9: in a full set the victim differs from the MRU way
        a_r9_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_q.fsm == ST_IDLE && cpu_req && !hit && (&ctl_q.valid[a_idx]))
            |=> (ctl_q.vway != $past(ctl_q.mru[a_idx])));
    end

endmodule

// File: tb/sim_cwb_cache.sv
`timescale 1ns/1ps
module sim_cwb_cache;

    localparam int AW = 16;
    localparam int BW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic          cpu_ready;
    logic [31:0]   cpu_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_wdata;
    logic [BW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    cwb_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Background memory contents, one word per aligned address
    function automatic logic [31:0] pat(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    logic [BW-1:0] store [int];
    logic [31:0]   shadow [int];

    function automatic logic [BW-1:0] blk_rd(input logic [AW-1:0] base);
        logic [BW-1:0] b;
        if (store.exists(int'(base))) return store[int'(base)];
        for (int i = 0; i < 4; i++) b[32*i +: 32] = pat(base + AW'(4*i));
        return b;
    endfunction

    function automatic logic [31:0] shadow_rd(input logic [AW-1:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return pat(a);
    endfunction

    // Memory responder and traffic log
    int cyc = 0;
    int wb_cnt = 0, fill_cnt = 0, wb_time = 0, fill_time = 0;
    logic [AW-1:0] last_wb_addr = '0, last_fill_addr = '0;
    logic [BW-1:0] last_wb_data = '0;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                wait_cnt++;
                if (wait_cnt == 3) begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        store[int'(mem_addr)] = mem_wdata;
                        wb_cnt++; wb_time = cyc;
                        last_wb_addr = mem_addr; last_wb_data = mem_wdata;
                    end else begin
                        mem_rdata = blk_rd(mem_addr);
                        fill_cnt++; fill_time = cyc;
                        last_fill_addr = mem_addr;
                    end
                end
            end
        end
    end

    // Scoreboard: expected read data queued by the driver
    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        string         req;
    } exp_t;
    exp_t expq [$];

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected read completion", BW'(cpu_addr), '0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(cpu_rdata == e.data, e.req, $sformatf("read data @%0h", e.addr),
                        BW'(cpu_rdata), BW'(e.data));
                end
            end
        end
    end

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [31:0] wd,
                          input bit exp_hit, input string req);
        int waits;
        if (!we) begin
            exp_t e;
            e.addr = a; e.data = shadow_rd(a); e.req = req;
            expq.push_back(e);
        end
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        waits = 0;
        @(negedge clk);
        while (!cpu_ready) begin
            waits++;
            @(negedge clk);
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) shadow[int'(a)] = wd;
        chk((waits == 0) == exp_hit, req, $sformatf("hit status @%0h (waits)", a),
            BW'(waits == 0), BW'(exp_hit));
    endtask

    initial begin
        int f0, w0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        chk(cpu_ready == 1'b0, "R1", "ready after reset", BW'(cpu_ready), '0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", BW'(mem_req), '0);

        // R1 R2 R6: cold miss fetches block-aligned address, no write-back
        access(0, 16'h0000, '0, 0, "R1");
        chk(fill_cnt == 1, "R1", "fill count", BW'(fill_cnt), 1);
        chk(last_fill_addr == 16'h0000, "R2", "fill address", BW'(last_fill_addr), 0);
        chk(wb_cnt == 0, "R6", "no write-back on empty victim", BW'(wb_cnt), 0);

        // R3: hits at several word offsets
        access(0, 16'h0004, '0, 1, "R3");
        access(0, 16'h000C, '0, 1, "R3");

        // R4: store hit stays in the cache
        access(1, 16'h0008, 32'hDEADBEEF, 1, "R4");
        chk(fill_cnt == 1 && wb_cnt == 0, "R4", "no memory traffic on store hit",
            BW'(fill_cnt + wb_cnt), 1);
        access(0, 16'h0008, '0, 1, "R4");

        // R8: second block in set 0 goes to the empty way
        access(0, 16'h0040, '0, 0, "R8");
        access(0, 16'h0000, '0, 1, "R8");

        // R9 R6: set full, MRU is 0x0000, so clean 0x0040 is replaced
        access(0, 16'h0080, '0, 0, "R9");
        chk(wb_cnt == 0, "R6", "clean victim not written back", BW'(wb_cnt), 0);
        access(0, 16'h0000, '0, 1, "R9");
        access(0, 16'h0040, '0, 0, "R9");

        // R5: MRU now 0x0040, dirty 0x0000 is evicted with write-back first
        f0 = fill_cnt;
        access(0, 16'h00C0, '0, 0, "R5");
        chk(wb_cnt == 1, "R5", "write-back count", BW'(wb_cnt), 1);
        chk(last_wb_addr == 16'h0000, "R5", "write-back address", BW'(last_wb_addr), 0);
        chk(last_wb_data[95:64] == 32'hDEADBEEF, "R5", "written-back stored word",
            BW'(last_wb_data[95:64]), BW'(32'hDEADBEEF));
        chk(last_wb_data[31:0] == pat(16'h0000), "R5", "written-back clean word",
            BW'(last_wb_data[31:0]), BW'(pat(16'h0000)));
        chk(wb_time < fill_time && fill_cnt == f0 + 1, "R5", "write-back precedes fetch",
            BW'(wb_time), BW'(fill_time));
        chk(last_fill_addr == 16'h00C0, "R5", "fetch after write-back", BW'(last_fill_addr), BW'(16'h00C0));
        // Data written back is seen again from memory
        access(0, 16'h0008, '0, 0, "R5");
        chk(wb_cnt == 1, "R6", "clean victim on refetch", BW'(wb_cnt), 1);

        // R7: store miss allocates, then writes
        w0 = wb_cnt;
        access(1, 16'h0114, 32'h12345678, 0, "R7");
        chk(last_fill_addr == 16'h0110, "R7", "store-miss fetch address", BW'(last_fill_addr), BW'(16'h0110));
        chk(wb_cnt == w0, "R7", "no write-back for empty way", BW'(wb_cnt), BW'(w0));
        access(0, 16'h0114, '0, 1, "R7");
        access(0, 16'h0110, '0, 1, "R7");
        access(0, 16'h0150, '0, 0, "R8");
        access(0, 16'h0190, '0, 0, "R7");
        chk(wb_cnt == w0 + 1, "R7", "modified line written back", BW'(wb_cnt), BW'(w0 + 1));
        chk(last_wb_addr == 16'h0110, "R7", "write-back address", BW'(last_wb_addr), BW'(16'h0110));
        chk(last_wb_data[63:32] == 32'h12345678, "R7", "merged store word",
            BW'(last_wb_data[63:32]), BW'(32'h12345678));
        chk(last_wb_data[95:64] == pat(16'h0118), "R7", "merged fetched word",
            BW'(last_wb_data[95:64]), BW'(pat(16'h0118)));

        // R2: other set untouched by set-2 traffic
        access(0, 16'h0020, '0, 0, "R2");
        chk(last_fill_addr == 16'h0020, "R2", "set-2 fetch address", BW'(last_fill_addr), BW'(16'h0020));
        access(0, 16'h0158, '0, 1, "R2");
        access(0, 16'h00C4, '0, 1, "R2");

        // R10: nothing left pending, queue drained
        @(negedge clk);
        chk(mem_req == 1'b0, "R10", "memory idle at end", BW'(mem_req), 0);
        chk(expq.size() == 0, "R10", "all reads completed", BW'(expq.size()), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule